// File: doc/BRIEF.md
# Hub/LPC Memory Cycle Target Decoder

This block sits on the target side of a flash device's 4-bit host bus. It watches an active-low frame strobe and a 4-bit nibble bus, both sampled on the rising clock edge. It works out from the START nibble which of two bus dialects the host is speaking: a hub-style cycle or an LPC cycle. It then collects the address nibbles. A memory read fetches one byte and returns it over the bus. A memory write captures one byte. Each access is routed to either an array port or a register port.

The two dialects differ in three ways. A hub-style cycle carries 7 address nibbles and picks its target with address bit 22. An LPC cycle first sends a cycle-type nibble, then 8 address nibbles, and claims the access only when the upper address bits match the device window. The two dialects also react differently to a frame strobe that arrives mid-cycle. In a hub-style cycle it forces an abort, and the block then waits for the 1111b abort nibble. In an LPC cycle it simply starts a new frame.

After the address (and, for writes, the data), the target answers in a fixed order:
- one released turnaround clock;
- one clock driving 1111b;
- a ready sync nibble of 0000b;
- for reads, the data byte, least-significant nibble first;
- one clock driving 1111b;
- one released clock.

Top module: `fwh_lpc_target`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle on that edge: `nib_oe` is low and no strobe is raised, even in the middle of a read response.
- R2: A frame-low START of 1101b begins a hub-style read, and 1110b begins a hub-style write. Seven address nibbles follow, most-significant first, forming a 28-bit address.
- R3: A frame-low START of 0000b begins an LPC cycle. The next nibble is the cycle type: 010x means memory read and 011x means memory write. Eight address nibbles follow, most-significant first.
- R4: A hub-style access goes to the array port when address bit 22 is 1 and to the register port when it is 0. `arr_addr` is address[ARR_AW-1:0] and `reg_addr` is address[REG_AW-1:0].
- R5: An LPC access goes to the array port when every address bit from 31 down to ARR_AW is 1. Otherwise it goes to the register port when bits 31..23 are all 1 and bit 22 is 0. Otherwise the block does not respond: no strobe is raised and the bus is never driven.
- R6: Write data arrives in the two nibbles after the address, low nibble first. A single-cycle write strobe (`arr_wr` or `reg_wr`) is raised with `wr_data` and the address valid. At most one strobe is high at any time.
- R7: A read raises a single-cycle `arr_rd` or `reg_rd` strobe with the address valid. The selected read-data input is sampled at the end of that cycle and returned after the sync nibble, low nibble first.
- R8: The response to a claimed access runs as follows:
  - the strobe cycle, with the bus released;
  - 1111b;
  - 0000b;
  - for reads only, the two data nibbles;
  - 1111b;
  - a released clock;
  - then idle.
- R9: In a hub-style cycle, a frame-low nibble after the START releases the bus on that edge. If that nibble is 1111b the block goes idle; otherwise it ignores all traffic until it samples frame low with 1111b.
- R10: In an LPC cycle, a frame-low nibble after the START restarts START capture, so a new cycle can begin at once.
- R11: An unrecognised START nibble, or an LPC cycle type other than 010x/011x, makes the block ignore the frame until the next frame strobe.
- R12: When the frame strobe stays low for several clocks, the START is the nibble sampled on the last low clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| nib_in | input | 4 | Nibble bus as seen by the target |
| nib_out | output | 4 | Nibble the target drives |
| nib_oe | output | 1 | Target drive enable for the nibble bus |
| arr_rd | output | 1 | Single-cycle array read strobe |
| arr_wr | output | 1 | Single-cycle array write strobe |
| arr_addr | output | ARR_AW | Array byte address |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_addr | output | REG_AW | Register byte address |
| wr_data | output | 8 | Captured write byte |
| arr_rdata | input | 8 | Array read data, sampled in the read strobe cycle |
| reg_rdata | input | 8 | Register read data, sampled in the read strobe cycle |

## Verification
The bench aims at the points where the two dialects part ways.

An abort nibble in the middle of the response must release the bus at once in a hub cycle, while a design that restarted there would decode a fresh hub START during the abort wait. A frame strobe in the middle of an LPC cycle must start a new frame, and a design that treated it as a hub abort would miss the next LPC access. LPC addresses just outside the window must draw no response at all, and a mis-sized comparison would claim them.

Reset asserted during the data nibbles, unrecognised START and cycle-type values, and a stretched frame strobe are also exercised. An off-by-one nibble counter or a swapped data-nibble order shows up as a mismatch on the very clock where it happens.

// File: rtl/fwh_lpc_pkg.sv
// Shared types and nibble codes for the hub/LPC memory cycle target.
// Assumes a 4-bit nibble bus sampled on the rising clock edge.
package fwh_lpc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_WDATA,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC,
        ST_RD0,
        ST_RD1,
        ST_END0,
        ST_END1,
        ST_WAIT_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ARRAY,
        TGT_REG
    } target_t;

    localparam logic [3:0] NIB_HUB_RD    = 4'b1101;
    localparam logic [3:0] NIB_HUB_WR    = 4'b1110;
    localparam logic [3:0] NIB_LPC_START = 4'b0000;
    localparam logic [3:0] NIB_ABORT     = 4'b1111;
    localparam logic [3:0] NIB_TURN      = 4'b1111;
    localparam logic [3:0] NIB_READY     = 4'b0000;
    localparam logic [2:0] CT_MEM_RD     = 3'b010;
    localparam logic [2:0] CT_MEM_WR     = 3'b011;

    localparam int HUB_ADDR_NIBS = 7;
    localparam int LPC_ADDR_NIBS = 8;
    localparam int BUS_ADDR_W    = 4 * LPC_ADDR_NIBS;

endpackage

// File: rtl/fwh_lpc_decode.sv
// Address-match decoder. Given the full address as it will stand after the
// current nibble, it decides which port (if any) the access belongs to.
// Assumes hub-style addresses arrive right-aligned in the low 28 bits.
module fwh_lpc_decode
    import fwh_lpc_pkg::*;
#(
    parameter int ARR_AW      = 18,
    parameter int REG_AW      = 16,
    parameter int HUB_SEL_BIT = 22
) (
    input  logic                  is_lpc,
    input  logic [BUS_ADDR_W-1:0] addr,
    output target_t               tgt,
    output logic [ARR_AW-1:0]     arr_addr,
    output logic [REG_AW-1:0]     reg_addr
);

    localparam int REG_WIN_LSB = HUB_SEL_BIT + 1;

    logic arr_hit;
    logic reg_hit;

    // Array window: every bit above the array size must be set.
    generate
        if (ARR_AW < BUS_ADDR_W) begin : g_arr_window
            assign arr_hit = &addr[BUS_ADDR_W-1:ARR_AW];
        end else begin : g_arr_full
            assign arr_hit = 1'b1;
        end
    endgenerate

    // Register window: upper bits set, select bit clear.
    assign reg_hit = (&addr[BUS_ADDR_W-1:REG_WIN_LSB]) & ~addr[HUB_SEL_BIT];

    // Pick the target per dialect.
    always_comb begin
        if (is_lpc) begin
            if (arr_hit)      tgt = TGT_ARRAY;
            else if (reg_hit) tgt = TGT_REG;
            else              tgt = TGT_NONE;
        end else begin
            tgt = addr[HUB_SEL_BIT] ? TGT_ARRAY : TGT_REG;
        end
    end

    assign arr_addr = addr[ARR_AW-1:0];
    assign reg_addr = addr[REG_AW-1:0];

endmodule

// File: rtl/fwh_lpc_seq.sv
// Field sequencer. Latches START, tells the dialects apart, counts address
// and data nibbles, raises the single-cycle access strobes and walks the
// response phases. Handles hub aborts and LPC frame restarts.
// Assumes frame_n and nib_in are synchronous to clk.
module fwh_lpc_seq
    import fwh_lpc_pkg::*;
#(
    parameter int ARR_AW = 18,
    parameter int REG_AW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_n,
    input  logic [3:0]            nib_in,
    input  target_t               tgt_in,
    input  logic [ARR_AW-1:0]     arr_addr_in,
    input  logic [REG_AW-1:0]     reg_addr_in,
    output logic [BUS_ADDR_W-1:0] addr_next,
    output logic                  is_lpc,
    output seq_state_t            state,
    output target_t               tgt_q,
    output logic [ARR_AW-1:0]     arr_addr_q,
    output logic [REG_AW-1:0]     reg_addr_q,
    output logic [7:0]            wdata_q,
    output logic                  arr_rd,
    output logic                  arr_wr,
    output logic                  reg_rd,
    output logic                  reg_wr
);

    localparam int CNT_W  = $clog2(LPC_ADDR_NIBS + 1);
    localparam int HOLD_W = BUS_ADDR_W - 4;

    logic [3:0]        start_q;
    logic              is_wr;
    logic [HOLD_W-1:0] addr_q;
    logic [CNT_W-1:0]  nib_cnt;
    logic [CNT_W-1:0]  last_cnt;
    logic              restart_ok;

    // Address as it stands once the current nibble is shifted in.
    assign addr_next = {addr_q, nib_in};

    // Index of the final address nibble for the active dialect.
    assign last_cnt = is_lpc ? CNT_W'(LPC_ADDR_NIBS - 1) : CNT_W'(HUB_ADDR_NIBS - 1);

    // Frame low is taken as a new START when idle, already in START, or mid-LPC.
    assign restart_ok = (state == ST_IDLE) || (state == ST_START)
                        || (is_lpc && state != ST_WAIT_ABORT);

    // Main sequencing register block.
    always_ff @(posedge clk) begin : p_seq
        arr_rd <= 1'b0;
        arr_wr <= 1'b0;
        reg_rd <= 1'b0;
        reg_wr <= 1'b0;
        if (!rst_n) begin
            state      <= ST_IDLE;
            start_q    <= '0;
            is_lpc     <= 1'b0;
            is_wr      <= 1'b0;
            addr_q     <= '0;
            nib_cnt    <= '0;
            wdata_q    <= '0;
            tgt_q      <= TGT_NONE;
            arr_addr_q <= '0;
            reg_addr_q <= '0;
        end else if (!frame_n && restart_ok) begin
            state   <= ST_START;
            start_q <= nib_in;
        end else if (!frame_n) begin
            state <= (nib_in == NIB_ABORT) ? ST_IDLE : ST_WAIT_ABORT;
        end else begin
            case (state)
                ST_START: begin
                    if (start_q == NIB_HUB_RD || start_q == NIB_HUB_WR) begin
                        is_lpc  <= 1'b0;
                        is_wr   <= (start_q == NIB_HUB_WR);
                        addr_q  <= {{(HOLD_W-4){1'b0}}, nib_in};
                        nib_cnt <= CNT_W'(1);
                        state   <= ST_ADDR;
                    end else if (start_q == NIB_LPC_START
                                 && (nib_in[3:1] == CT_MEM_RD || nib_in[3:1] == CT_MEM_WR)) begin
                        is_lpc  <= 1'b1;
                        is_wr   <= (nib_in[3:1] == CT_MEM_WR);
                        addr_q  <= '0;
                        nib_cnt <= '0;
                        state   <= ST_ADDR;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    addr_q  <= addr_next[HOLD_W-1:0];
                    nib_cnt <= nib_cnt + CNT_W'(1);
                    if (nib_cnt == last_cnt) begin
                        nib_cnt    <= '0;
                        tgt_q      <= tgt_in;
                        arr_addr_q <= arr_addr_in;
                        reg_addr_q <= reg_addr_in;
                        if (tgt_in == TGT_NONE) begin
                            state <= ST_IDLE;
                        end else if (is_wr) begin
                            state <= ST_WDATA;
                        end else begin
                            state  <= ST_TAR0;
                            arr_rd <= (tgt_in == TGT_ARRAY);
                            reg_rd <= (tgt_in == TGT_REG);
                        end
                    end
                end
                ST_WDATA: begin
                    if (nib_cnt == '0) begin
                        wdata_q[3:0] <= nib_in;
                        nib_cnt      <= CNT_W'(1);
                    end else begin
                        wdata_q[7:4] <= nib_in;
                        nib_cnt      <= '0;
                        state        <= ST_TAR0;
                        arr_wr       <= (tgt_q == TGT_ARRAY);
                        reg_wr       <= (tgt_q == TGT_REG);
                    end
                end
                ST_TAR0:  state <= ST_TAR1;
                ST_TAR1:  state <= ST_SYNC;
                ST_SYNC:  state <= is_wr ? ST_END0 : ST_RD0;
                ST_RD0:   state <= ST_RD1;
                ST_RD1:   state <= ST_END0;
                ST_END0:  state <= ST_END1;
                ST_END1:  state <= ST_IDLE;
                default:  state <= state;
            endcase
        end
    end

endmodule

// File: rtl/fwh_lpc_drive.sv
// Response driver. Samples read data in the strobe cycle and maps the
// response phase to the nibble and drive enable placed on the bus.
// Assumes the read-data inputs are valid during the strobe cycle.
module fwh_lpc_drive
    import fwh_lpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  target_t    tgt_q,
    input  logic [7:0] arr_rdata,
    input  logic [7:0] reg_rdata,
    output logic [3:0] nib_out,
    output logic       nib_oe
);

    logic [7:0] rdata_q;

    // Capture the selected read byte at the end of the strobe cycle.
    always_ff @(posedge clk) begin : p_rdata
        if (!rst_n)                 rdata_q <= '0;
        else if (state == ST_TAR0)  rdata_q <= (tgt_q == TGT_REG) ? reg_rdata : arr_rdata;
    end

    // Phase-to-bus mapping.
    always_comb begin : p_bus
        nib_oe  = 1'b1;
        nib_out = NIB_TURN;
        case (state)
            ST_TAR1: nib_out = NIB_TURN;
            ST_SYNC: nib_out = NIB_READY;
            ST_RD0:  nib_out = rdata_q[3:0];
            ST_RD1:  nib_out = rdata_q[7:4];
            ST_END0: nib_out = NIB_TURN;
            default: begin
                nib_oe  = 1'b0;
                nib_out = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/fwh_lpc_target.sv
// Top of the hub/LPC memory cycle target: sequencer, address decoder and
// response driver. One byte per cycle, routed to the array or register port.
// Assumes synchronous active-low reset and a single bus clock.
module fwh_lpc_target
    import fwh_lpc_pkg::*;
#(
    parameter int ARR_AW      = 18,
    parameter int REG_AW      = 16,
    parameter int HUB_SEL_BIT = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        nib_in,
    output logic [3:0]        nib_out,
    output logic              nib_oe,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic [ARR_AW-1:0] arr_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        wr_data,
    input  logic [7:0]        arr_rdata,
    input  logic [7:0]        reg_rdata
);

    logic [BUS_ADDR_W-1:0] addr_next;
    logic                  is_lpc;
    seq_state_t            state;
    target_t               tgt_dec;
    target_t               tgt_q;
    logic [ARR_AW-1:0]     arr_addr_dec;
    logic [REG_AW-1:0]     reg_addr_dec;

    fwh_lpc_decode #(
        .ARR_AW      (ARR_AW),
        .REG_AW      (REG_AW),
        .HUB_SEL_BIT (HUB_SEL_BIT)
    ) u_decode (
        .is_lpc   (is_lpc),
        .addr     (addr_next),
        .tgt      (tgt_dec),
        .arr_addr (arr_addr_dec),
        .reg_addr (reg_addr_dec)
    );

    fwh_lpc_seq #(
        .ARR_AW (ARR_AW),
        .REG_AW (REG_AW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .nib_in      (nib_in),
        .tgt_in      (tgt_dec),
        .arr_addr_in (arr_addr_dec),
        .reg_addr_in (reg_addr_dec),
        .addr_next   (addr_next),
        .is_lpc      (is_lpc),
        .state       (state),
        .tgt_q       (tgt_q),
        .arr_addr_q  (arr_addr),
        .reg_addr_q  (reg_addr),
        .wdata_q     (wr_data),
        .arr_rd      (arr_rd),
        .arr_wr      (arr_wr),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr)
    );

    fwh_lpc_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .tgt_q     (tgt_q),
        .arr_rdata (arr_rdata),
        .reg_rdata (reg_rdata),
        .nib_out   (nib_out),
        .nib_oe    (nib_oe)
    );

endmodule

// File: rtl/fwh_lpc_target_chk.sv
// Port-level protocol checker for fwh_lpc_target, bound to every instance.
// Assumes synchronous active-low reset.
module fwh_lpc_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] nib_out,
    input logic       nib_oe,
    input logic       arr_rd,
    input logic       arr_wr,
    input logic       reg_rd,
    input logic       reg_wr
);

    logic rst_seen_low = 1'b0;

    // Remember whether the last edge saw reset.
    always @(posedge clk) rst_seen_low <= !rst_n;

    // R1: after an edge with reset low the block is quiet.
    always @(negedge clk) begin
        if (rst_seen_low) begin
            assert_reset_quiet_R1: assert (!nib_oe && !arr_rd && !arr_wr && !reg_rd && !reg_wr)
                else $error("reset did not quiet the block");
        end
    end

    // R6: never more than one strobe at a time.
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, arr_wr, reg_rd, reg_wr}));

    // R6: write strobes last one cycle.
    assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr || reg_wr) |=> !(arr_wr || reg_wr));

    // R7: read strobe is followed by the target taking the bus with 1111b.
    assert_rd_then_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((arr_rd || reg_rd) && frame_n) |=> (nib_oe && nib_out == 4'hF));

    // R8: bus released during the strobe cycle.
    assert_strobe_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd || arr_wr || reg_rd || reg_wr) |-> !nib_oe);

    // R8: the first driven nibble of a response is 1111b.
    assert_first_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_oe) |-> (nib_out == 4'hF));

endmodule

bind fwh_lpc_target fwh_lpc_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .nib_out (nib_out),
    .nib_oe  (nib_oe),
    .arr_rd  (arr_rd),
    .arr_wr  (arr_wr),
    .reg_rd  (reg_rd),
    .reg_wr  (reg_wr)
);

// File: tb/fwh_lpc_target_test.sv
// Bench: per-clock expected bus and strobe values derived from the
// requirements and compared after every rising edge.
module fwh_lpc_target_test;

    localparam int ARR_AW = 18;
    localparam int REG_AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_n = 1'b1;
    logic [3:0]        nib_in = 4'hF;
    logic [3:0]        nib_out;
    logic              nib_oe;
    logic              arr_rd, arr_wr, reg_rd, reg_wr;
    logic [ARR_AW-1:0] arr_addr;
    logic [REG_AW-1:0] reg_addr;
    logic [7:0]        wr_data;
    logic [7:0]        arr_rdata = 8'h00;
    logic [7:0]        reg_rdata = 8'h00;

    int          total = 0;
    int          bad   = 0;
    logic [31:0] cur_a = '0;
    logic [7:0]  cur_wd = '0;

    fwh_lpc_target #(.ARR_AW(ARR_AW), .REG_AW(REG_AW), .HUB_SEL_BIT(22)) uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
        .nib_out(nib_out), .nib_oe(nib_oe),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_addr(arr_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .wr_data(wr_data), .arr_rdata(arr_rdata), .reg_rdata(reg_rdata)
    );

    always #5 clk = ~clk;

    // Target choice per R4/R5: 0 none, 1 array, 2 register.
    function automatic int exp_target(input bit lpc, input logic [31:0] a);
        if (!lpc) return a[22] ? 1 : 2;
        if (&a[31:18]) return 1;
        if (&a[31:23] && !a[22]) return 2;
        return 0;
    endfunction

    // One clock: drive at the falling edge, compare just after the rising edge.
    task automatic step(input logic rs, input logic fr, input logic [3:0] nb,
                        input logic e_oe, input logic [3:0] e_nib,
                        input logic [3:0] e_req, input string rq);
        logic [3:0] got;
        @(negedge clk);
        rst_n = rs; frame_n = fr; nib_in = nb;
        @(posedge clk);
        #1;
        got = {reg_wr, reg_rd, arr_wr, arr_rd};
        total++;
        if (nib_oe !== e_oe || (e_oe && nib_out !== e_nib) || got !== e_req) begin
            bad++;
            $display("FAIL %s: oe=%b nib=%h strobes=%b expected oe=%b nib=%h strobes=%b",
                     rq, nib_oe, nib_out, got, e_oe, e_nib, e_req);
        end
        if (e_req[0] || e_req[1]) begin
            total++;
            if (arr_addr !== cur_a[ARR_AW-1:0]) begin
                bad++;
                $display("FAIL %s: arr_addr=%h expected %h", rq, arr_addr, cur_a[ARR_AW-1:0]);
            end
        end
        if (e_req[2] || e_req[3]) begin
            total++;
            if (reg_addr !== cur_a[REG_AW-1:0]) begin
                bad++;
                $display("FAIL %s: reg_addr=%h expected %h", rq, reg_addr, cur_a[REG_AW-1:0]);
            end
        end
        if (e_req[1] || e_req[3]) begin
            total++;
            if (wr_data !== cur_wd) begin
                bad++;
                $display("FAIL %s: wr_data=%h expected %h", rq, wr_data, cur_wd);
            end
        end
    endtask

    task automatic st(input logic fr, input logic [3:0] nb, input logic e_oe,
                      input logic [3:0] e_nib, input logic [3:0] e_req, input string rq);
        step(1'b1, fr, nb, e_oe, e_nib, e_req, rq);
    endtask

    // Full cycle; cut >= 0 stops after that many response clocks.
    task automatic xfer(input bit lpc, input bit wr, input logic [31:0] a,
                        input logic [7:0] wd, input logic [7:0] ra, input logic [7:0] rr,
                        input int cut, input string rq);
        int         tgt;
        logic [3:0] req;
        logic [7:0] rdv;
        logic       eo [6];
        logic [3:0] en [6];
        int         n;
        tgt = exp_target(lpc, a);
        cur_a = a; cur_wd = wd; arr_rdata = ra; reg_rdata = rr;
        rdv = (tgt == 2) ? rr : ra;
        case (tgt)
            1:       req = wr ? 4'b0010 : 4'b0001;
            2:       req = wr ? 4'b1000 : 4'b0100;
            default: req = 4'b0000;
        endcase
        if (lpc) begin
            st(1'b0, 4'h0, 1'b0, 4'h0, 4'b0, rq);
            st(1'b1, wr ? 4'h6 : 4'h4, 1'b0, 4'h0, 4'b0, rq);
            n = 8;
        end else begin
            st(1'b0, wr ? 4'hE : 4'hD, 1'b0, 4'h0, 4'b0, rq);
            n = 7;
        end
        for (int i = n - 1; i >= 0; i--)
            st(1'b1, a[i*4 +: 4], 1'b0, 4'h0, (i == 0 && !wr) ? req : 4'b0, rq);
        if (wr) begin
            st(1'b1, wd[3:0], 1'b0, 4'h0, 4'b0, rq);
            st(1'b1, wd[7:4], 1'b0, 4'h0, req, rq);
        end
        if (tgt != 0) begin
            n = 0;
            eo[n] = 1'b1; en[n] = 4'hF; n++;
            eo[n] = 1'b1; en[n] = 4'h0; n++;
            if (!wr) begin
                eo[n] = 1'b1; en[n] = rdv[3:0]; n++;
                eo[n] = 1'b1; en[n] = rdv[7:4]; n++;
            end
            eo[n] = 1'b1; en[n] = 4'hF; n++;
            eo[n] = 1'b0; en[n] = 4'h0; n++;
            if (cut >= 0 && cut < n) n = cut;
            for (int k = 0; k < n; k++)
                st(1'b1, 4'hF, eo[k], en[k], 4'b0, rq);
        end
        if (cut < 0) st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, rq);
    endtask

    initial begin
        #(10 * 150000);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R1 reset");
        step(1'b0, 1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R1 reset");
        st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R1 idle after reset");

        // R2 R4 R7 R8: hub reads and writes to both ports
        xfer(1'b0, 1'b0, 32'h0FC1234, 8'h00, 8'hA5, 8'h3C, -1, "R2 R4 R7 R8 hub array read");
        xfer(1'b0, 1'b1, 32'h0F4ABCD, 8'h96, 8'h00, 8'h00, -1, "R2 R4 R6 hub array write");
        xfer(1'b0, 1'b0, 32'h0BC0100, 8'h00, 8'h11, 8'h1E, -1, "R4 R7 hub register read");
        xfer(1'b0, 1'b1, 32'h0BC0002, 8'h07, 8'h00, 8'h00, -1, "R4 R6 hub register write");

        // R3 R5: LPC accesses inside and outside the windows
        xfer(1'b1, 1'b0, 32'hFFFC5A5A, 8'h00, 8'hC3, 8'h00, -1, "R3 R5 lpc array read");
        xfer(1'b1, 1'b1, 32'hFFFE0001, 8'h5A, 8'h00, 8'h00, -1, "R3 R5 R6 lpc array write");
        xfer(1'b1, 1'b0, 32'hFFBC0100, 8'h00, 8'h00, 8'h8E, -1, "R5 lpc register read");
        xfer(1'b1, 1'b0, 32'h7FFC0000, 8'h00, 8'hFF, 8'hFF, -1, "R5 lpc no match read");
        xfer(1'b1, 1'b1, 32'hFFF00000, 8'h44, 8'h00, 8'h00, -1, "R5 lpc no match write");

        // R11: unrecognised START and cycle type are ignored
        st(1'b0, 4'h5, 1'b0, 4'h0, 4'b0, "R11 bad start");
        for (int i = 0; i < 9; i++) st(1'b1, 4'hD, 1'b0, 4'h0, 4'b0, "R11 bad start ignored");
        st(1'b0, 4'h0, 1'b0, 4'h0, 4'b0, "R11 lpc start");
        st(1'b1, 4'h2, 1'b0, 4'h0, 4'b0, "R11 bad cycle type");
        for (int i = 0; i < 9; i++) st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R11 bad type ignored");

        // R12: stretched frame, last low nibble is the START
        st(1'b0, 4'h5, 1'b0, 4'h0, 4'b0, "R12 stretched frame");
        xfer(1'b1, 1'b0, 32'hFFFD0042, 8'h00, 8'h69, 8'h00, -1, "R12 stretched frame lpc read");

        // R9: hub abort during the address, then wait for 1111b
        st(1'b0, 4'hD, 1'b0, 4'h0, 4'b0, "R9 hub start");
        st(1'b1, 4'h0, 1'b0, 4'h0, 4'b0, "R9 addr");
        st(1'b1, 4'h4, 1'b0, 4'h0, 4'b0, "R9 addr");
        st(1'b0, 4'h5, 1'b0, 4'h0, 4'b0, "R9 abort strobe");
        st(1'b0, 4'hD, 1'b0, 4'h0, 4'b0, "R9 start ignored while waiting");
        for (int i = 0; i < 9; i++) st(1'b1, 4'h4, 1'b0, 4'h0, 4'b0, "R9 waiting for abort");
        st(1'b0, 4'hF, 1'b0, 4'h0, 4'b0, "R9 abort nibble");
        xfer(1'b0, 1'b0, 32'h0400010, 8'h00, 8'h2B, 8'h00, -1, "R9 recovery read");

        // R9: abort in the read response releases the bus at once
        xfer(1'b0, 1'b0, 32'h0400020, 8'h00, 8'h77, 8'h00, 2, "R9 read before abort");
        st(1'b0, 4'h3, 1'b0, 4'h0, 4'b0, "R9 abort mid response");
        st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R9 still released");
        st(1'b0, 4'hF, 1'b0, 4'h0, 4'b0, "R9 abort nibble");
        xfer(1'b0, 1'b0, 32'h0400030, 8'h00, 8'hE1, 8'h00, 0, "R9 read then direct abort");
        st(1'b0, 4'hF, 1'b0, 4'h0, 4'b0, "R9 direct abort");
        st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R9 idle after direct abort");
        xfer(1'b0, 1'b1, 32'h0400031, 8'hB2, 8'h00, 8'h00, -1, "R9 recovery write");

        // R10: LPC frame mid response restarts capture
        xfer(1'b1, 1'b0, 32'hFFFC0010, 8'h00, 8'h5D, 8'h00, 2, "R10 lpc read before restart");
        st(1'b0, 4'h0, 1'b0, 4'h0, 4'b0, "R10 lpc restart releases bus");
        xfer(1'b1, 1'b0, 32'hFFFC0011, 8'h00, 8'hD5, 8'h00, -1, "R10 lpc read after restart");

        // R1: reset mid read response
        xfer(1'b0, 1'b0, 32'h0412345, 8'h00, 8'h9F, 8'h00, 3, "R1 read before reset");
        step(1'b0, 1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R1 reset mid read");
        st(1'b1, 4'hF, 1'b0, 4'h0, 4'b0, "R1 idle after reset");
        xfer(1'b0, 1'b0, 32'h0412346, 8'h00, 8'h60, 8'h00, -1, "R1 read after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule